// File: doc/BRIEF.md
# Metropolis Spin-Flip Annealer

The block searches for a low-energy configuration of `N` binary spins joined by couplings of value plus or minus one, using simulated annealing. Couplings and spins are loaded one at a time while the block is idle. A start pulse then seeds a 16-bit pseudo-random generator and computes the energy of the loaded configuration. After that the block runs a fixed number of trials at each of a programmable number of temperature steps.

Each trial picks a spin index at random. It sums the local field of that spin serially, one neighbour per cycle, and forms the energy change the flip would cause. A flip that does not raise the energy is always taken. An uphill flip is taken when a fresh random value falls below an acceptance threshold. That threshold is computed from the temperature step and the size of the change, and it approximates exp(-dE/T) with a falling temperature. A running energy register follows every accepted flip, so the spin vector and its energy can be read at any time.

Top module: `spin_annealer`

## Requirements
- R1: After reset, busy and done are low, energy reads 0, every spin reads 0 and every coupling is -1. Bit value 1 encodes +1 and bit value 0 encodes -1 for both spins and couplings.
- R2: A coupling write (row, column, value) or a spin write (index, value) takes effect at the next clock edge while busy is low. It is ignored while busy is high or when the address is N or more.
- R3: A start pulse while busy is low loads the seed into the generator (a zero seed is replaced by 1). It sets the energy register to E = -sum over i<j of J_ij*x_i*x_j for a symmetric coupling matrix, and only then begins the trials.
- R4: The generator steps as next = {g[14:0], g[15]^g[13]^g[12]^g[10]}. For each index draw it steps once and uses the low ceil(log2 N) bits as the index. A value of N or more is discarded and the draw repeats.
- R5: The candidate change is dE = 2*x_i*sum over j!=i of J_ij*x_j. A candidate with dE <= 0 is always flipped.
- R6: For dE > 0 the generator steps once more. The flip is taken when that new 16-bit value is strictly below the threshold P(s,k), where k = dE/2, s is the temperature step and e = k*(s+1). P is 0 when e/2 >= 16. Otherwise P = 65535 >> (e/2), and for odd e that value is further multiplied by 46341 and shifted right by 16. The generator also steps once after dE <= 0 candidates.
- R7: The temperature step output starts at 0 and advances after trials_m1+1 trials. After steps_m1+1 steps the block stops with temp_step equal to steps_m1.
- R8: The energy register adds dE for every accepted flip, so at done it equals the energy of the spin vector on the readout port.
- R9: Done stays high and the spins stay unchanged until the next start. A start given while done is high anneals again from the current spins.
- R10: While busy, at most one spin bit changes per clock cycle, and the busy and done flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_we | input | 1 | Coupling write strobe |
| cpl_row | input | IW | Coupling row index |
| cpl_col | input | IW | Coupling column index |
| cpl_val | input | 1 | Coupling value, 1 = +1, 0 = -1 |
| spin_we | input | 1 | Spin write strobe |
| spin_idx | input | IW | Spin index |
| spin_val | input | 1 | Spin value, 1 = +1, 0 = -1 |
| seed | input | 16 | Generator seed sampled at start |
| steps_m1 | input | STEPW | Number of temperature steps minus one |
| trials_m1 | input | TRIALW | Trials per temperature step minus one |
| start | input | 1 | Start pulse |
| busy | output | 1 | Energy setup or annealing in progress |
| done | output | 1 | Last temperature step finished |
| spins | output | N | Current spin vector |
| energy | output | EW | Current energy, two's complement |
| temp_step | output | STEPW | Current temperature step |

## Verification
The assertions assume that the coupling matrix is symmetric, that steps_m1 stays unchanged from start to done, and that start is never given in the same cycle as a write. The bench always writes each coupling pair at both (i,j) and (j,i). It holds the schedule inputs steady for the whole run and issues start only after its writes are complete. Its writes during a run deliberately target an annealer that is busy, which tests the write lock-out without breaking the symmetry assumption for the run in progress.

// File: rtl/spin_annealer.sv
module spin_annealer #(
  parameter int N      = 12,
  parameter int STEPW  = 3,
  parameter int TRIALW = 10,
  localparam int IW    = $clog2(N),
  localparam int HW    = $clog2(N) + 2,
  localparam int KW    = HW - 1,
  localparam int DW    = HW + 1,
  localparam int EW    = $clog2(N * N) + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpl_we,
  input  logic [IW-1:0]        cpl_row,
  input  logic [IW-1:0]        cpl_col,
  input  logic                 cpl_val,
  input  logic                 spin_we,
  input  logic [IW-1:0]        spin_idx,
  input  logic                 spin_val,
  input  logic [15:0]          seed,
  input  logic [STEPW-1:0]     steps_m1,
  input  logic [TRIALW-1:0]    trials_m1,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [N-1:0]         spins,
  output logic signed [EW-1:0] energy,
  output logic [STEPW-1:0]     temp_step
);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_DRAW, S_SUM, S_EVAL, S_DONE} state_t;

  state_t             st;
  logic [N-1:0]       cpl [N];
  logic [N-1:0]       spin;
  logic [15:0]        gen;
  logic [IW-1:0]      ci, cj;
  logic signed [EW-1:0] acc, energy_q;
  logic signed [HW-1:0] h;
  logic [TRIALW-1:0]  trial;
  logic [STEPW-1:0]   stp;

  function automatic logic [15:0] accept_thr(input logic [STEPW-1:0] s, input logic [KW-1:0] k);
    int unsigned e, sh, m;
    logic [15:0] p;
    e  = int'(k) * (int'(s) + 1);
    sh = e / 2;
    if (sh >= 16) begin
      p = 16'd0;
    end else begin
      p = 16'hFFFF >> sh;
      if (e % 2 == 1) begin
        m = int'(p) * 46341;
        p = m[31:16];
      end
    end
    return p;
  endfunction

  wire [15:0] gen_nx  = {gen[14:0], gen[15] ^ gen[13] ^ gen[12] ^ gen[10]};
  wire [IW-1:0] pick  = gen_nx[IW-1:0];
  wire pick_ok        = int'({1'b0, pick}) < N;
  wire cj_last        = (cj == IW'(N - 1));
  wire ci_last        = (ci == IW'(N - 1));
  wire diag           = (ci == cj);
  wire cbit           = cpl[ci][cj];

  wire init_pos = cbit ^ spin[ci] ^ spin[cj];
  wire sum_pos  = (cbit == spin[cj]);

  logic signed [EW-1:0] acc_nx;
  logic signed [HW-1:0] h_nx;
  always_comb begin
    acc_nx = acc;
    if (!diag) acc_nx = acc + {{(EW-1){~init_pos}}, 1'b1};
    h_nx = h;
    if (!diag) h_nx = h + {{(HW-1){~sum_pos}}, 1'b1};
  end

  wire xi      = spin[ci];
  wire h_neg   = h[HW-1];
  wire h_pos   = !h_neg && (h != '0);
  wire uphill  = xi ? h_pos : h_neg;
  wire [KW-1:0] kmag = h_neg ? KW'(-h) : KW'(h);
  wire [DW-1:0] de_mag = {h, 1'b0};
  wire signed [DW-1:0] de = xi ? de_mag : -de_mag;
  wire accept  = !uphill || (gen_nx < accept_thr(stp, kmag));
  wire trial_end = (trial == trials_m1);
  wire step_end  = (stp == steps_m1);

  wire idle_like = (st == S_IDLE) || (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      spin     <= '0;
      gen      <= 16'd1;
      ci       <= '0;
      cj       <= '0;
      acc      <= '0;
      h        <= '0;
      energy_q <= '0;
      trial    <= '0;
      stp      <= '0;
      for (int r = 0; r < N; r++) cpl[r] <= '0;
    end else begin
      if (idle_like && cpl_we && int'({1'b0, cpl_row}) < N && int'({1'b0, cpl_col}) < N)
        cpl[cpl_row][cpl_col] <= cpl_val;
      if (idle_like && spin_we && int'({1'b0, spin_idx}) < N)
        spin[spin_idx] <= spin_val;

      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            gen   <= (seed == 16'd0) ? 16'd1 : seed;
            ci    <= '0;
            cj    <= '0;
            acc   <= '0;
            trial <= '0;
            stp   <= '0;
            st    <= S_INIT;
          end
        end
        S_INIT: begin
          acc <= acc_nx;
          if (cj_last) begin
            cj <= '0;
            if (ci_last) begin
              energy_q <= -(acc_nx >>> 1);
              st       <= S_DRAW;
            end else begin
              ci <= ci + 1'b1;
            end
          end else begin
            cj <= cj + 1'b1;
          end
        end
        S_DRAW: begin
          gen <= gen_nx;
          if (pick_ok) begin
            ci <= pick;
            cj <= '0;
            h  <= '0;
            st <= S_SUM;
          end
        end
        S_SUM: begin
          h <= h_nx;
          if (cj_last) st <= S_EVAL;
          else         cj <= cj + 1'b1;
        end
        S_EVAL: begin
          gen <= gen_nx;
          if (accept) begin
            spin[ci] <= ~spin[ci];
            energy_q <= energy_q + {{(EW-DW){de[DW-1]}}, de};
          end
          if (trial_end) begin
            trial <= '0;
            if (step_end) st <= S_DONE;
            else begin
              stp <= stp + 1'b1;
              st  <= S_DRAW;
            end
          end else begin
            trial <= trial + 1'b1;
            st    <= S_DRAW;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = !idle_like;
  assign done      = (st == S_DONE);
  assign spins     = spin;
  assign energy    = energy_q;
  assign temp_step = stp;

endmodule

// File: rtl/spin_annealer_chk.sv
module spin_annealer_chk #(
  parameter int N     = 12,
  parameter int STEPW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spin_we,
  input logic             busy,
  input logic             done,
  input logic [N-1:0]     spins,
  input logic [STEPW-1:0] temp_step,
  input logic [STEPW-1:0] steps_m1
);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_single_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(spins ^ $past(spins)) <= 1));

  assert_spins_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !spin_we) |=> $stable(spins));

  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (temp_step <= steps_m1));

  assert_done_last_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (temp_step == steps_m1));

endmodule

bind spin_annealer spin_annealer_chk #(.N(N), .STEPW(STEPW)) chk_i (
  .clk(clk), .rst_n(rst_n), .spin_we(spin_we), .busy(busy), .done(done),
  .spins(spins), .temp_step(temp_step), .steps_m1(steps_m1)
);

// File: tb/spin_annealer_tb_top.sv
module spin_annealer_tb_top;
  localparam int N      = 12;
  localparam int STEPW  = 3;
  localparam int TRIALW = 10;
  localparam int IW     = $clog2(N);
  localparam int EW     = $clog2(N * N) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpl_we = 1'b0, cpl_val = 1'b0, spin_we = 1'b0, spin_val = 1'b0, start = 1'b0;
  logic [IW-1:0] cpl_row = '0, cpl_col = '0, spin_idx = '0;
  logic [15:0] seed = '0;
  logic [STEPW-1:0] steps_m1 = '0;
  logic [TRIALW-1:0] trials_m1 = '0;
  logic busy, done;
  logic [N-1:0] spins;
  logic signed [EW-1:0] energy;
  logic [STEPW-1:0] temp_step;

  int n_checks = 0;
  int n_fail = 0;

  int mJ [N][N];
  int mx [N];
  int mE;

  always #2 clk = ~clk;

  spin_annealer #(.N(N), .STEPW(STEPW), .TRIALW(TRIALW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpl_we(cpl_we), .cpl_row(cpl_row), .cpl_col(cpl_col),
    .cpl_val(cpl_val), .spin_we(spin_we), .spin_idx(spin_idx), .spin_val(spin_val),
    .seed(seed), .steps_m1(steps_m1), .trials_m1(trials_m1), .start(start),
    .busy(busy), .done(done), .spins(spins), .energy(energy), .temp_step(temp_step)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen_step(input int g);
    int fb;
    fb = ((g >> 15) ^ (g >> 13) ^ (g >> 12) ^ (g >> 10)) & 1;
    return ((g << 1) & 16'hFFFF) | fb;
  endfunction

  function automatic int thr(input int s, input int k);
    int e, p;
    e = k * (s + 1);
    if (e / 2 >= 16) return 0;
    p = 65535 >> (e / 2);
    if (e % 2 == 1) p = (p * 46341) >> 16;
    return p;
  endfunction

  function automatic int model_energy();
    int e;
    e = 0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        e -= mJ[i][j] * mx[i] * mx[j];
    return e;
  endfunction

  function automatic int dut_energy_from_spins();
    int e;
    e = 0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        e -= mJ[i][j] * (spins[i] ? 1 : -1) * (spins[j] ? 1 : -1);
    return e;
  endfunction

  task automatic model_run(input int sd, input int st_m1, input int tr_m1);
    int g, i, h, de;
    g = (sd == 0) ? 1 : sd;
    mE = model_energy();
    for (int s = 0; s <= st_m1; s++) begin
      for (int t = 0; t <= tr_m1; t++) begin
        do g = gen_step(g); while ((g % (1 << IW)) >= N);
        i = g % (1 << IW);
        h = 0;
        for (int j = 0; j < N; j++)
          if (j != i) h += mJ[i][j] * mx[j];
        de = 2 * mx[i] * h;
        g = gen_step(g);
        if (de <= 0 || g < thr(s, (h < 0) ? -h : h)) begin
          mx[i] = -mx[i];
          mE += de;
        end
      end
    end
  endtask

  task automatic write_cpl(input int r, input int c, input int v);
    @(negedge clk);
    cpl_we = 1'b1; cpl_row = IW'(r); cpl_col = IW'(c); cpl_val = (v > 0);
    @(negedge clk);
    cpl_we = 1'b1; cpl_row = IW'(c); cpl_col = IW'(r);
    @(negedge clk);
    cpl_we = 1'b0;
  endtask

  task automatic write_spin(input int i, input int v);
    @(negedge clk);
    spin_we = 1'b1; spin_idx = IW'(i); spin_val = (v > 0);
    @(negedge clk);
    spin_we = 1'b0;
  endtask

  task automatic load_model();
    for (int i = 0; i < N; i++) write_spin(i, mx[i]);
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) write_cpl(i, j, mJ[i][j]);
  endtask

  task automatic start_run(input int sd, input int st_m1, input int tr_m1);
    @(negedge clk);
    seed = 16'(sd); steps_m1 = STEPW'(st_m1); trials_m1 = TRIALW'(tr_m1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int cnt;
    cnt = 0;
    while (!done && cnt < 50000) begin
      @(negedge clk);
      cnt++;
    end
    check({req, " done reached"}, int'(done), 1);
  endtask

  task automatic compare_result(input string req, input int st_m1);
    int exp_spins;
    exp_spins = 0;
    for (int i = 0; i < N; i++) if (mx[i] > 0) exp_spins |= (1 << i);
    check({req, " spins (R5 R6 R4)"}, int'(spins), exp_spins);
    check({req, " energy (R8)"}, int'(energy), mE);
    check({req, " energy matches spins (R8)"}, int'(energy), dut_energy_from_spins());
    check({req, " last step (R7)"}, int'(temp_step), st_m1);
    check({req, " busy low (R10)"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 energy", int'(energy), 0);
    check("R1 spins", int'(spins), 0);
  endtask

  task automatic t_load_and_initial_energy();
    for (int i = 0; i < N; i++) begin
      mx[i] = (i % 3 == 0) ? 1 : -1;
      for (int j = 0; j < N; j++) mJ[i][j] = -1;
    end
    for (int i = 0; i < N; i++) write_spin(i, mx[i]);
    write_spin(N + 2 < (1 << IW) ? N + 2 : 0, mx[0]);
    check("R2 spin readout", int'(spins), 12'h249);
    start_run(16'h1234, 0, 0);
    while (busy && !(dut_i.st == dut_i.S_SUM)) @(negedge clk);
    check("R3 initial energy all -1 couplings", int'(energy), model_energy());
    wait_done("R3");
  endtask

  task automatic t_ferro();
    for (int i = 0; i < N; i++) begin
      mx[i] = (i % 2 == 0) ? 1 : -1;
      for (int j = 0; j < N; j++) mJ[i][j] = 1;
    end
    load_model();
    start_run(16'hACE1, 2, 19);
    model_run(16'hACE1, 2, 19);
    wait_done("R7 ferro");
    compare_result("R5 ferro", 2);
  endtask

  task automatic t_mixed_zero_seed();
    for (int i = 0; i < N; i++) begin
      mx[i] = ((i * 5) % 7 < 3) ? 1 : -1;
      for (int j = 0; j < N; j++) mJ[i][j] = (((i * j + i + j) % 3) == 0) ? 1 : -1;
    end
    load_model();
    start_run(0, 7, 29);
    model_run(0, 7, 29);
    wait_done("R3 zero seed");
    compare_result("R6 mixed zero seed", 7);
  endtask

  task automatic t_ignore_busy();
    int snap;
    start_run(16'h5A5A, 3, 24);
    model_run(16'h5A5A, 3, 24);
    @(negedge clk);
    check("R2 busy during run", int'(busy), 1);
    spin_we = 1'b1; spin_idx = '0; spin_val = ~spins[0];
    cpl_we = 1'b1; cpl_row = 0; cpl_col = 1; cpl_val = ~cpl_val;
    @(negedge clk);
    spin_we = 1'b0; cpl_we = 1'b0;
    wait_done("R2 writes while busy");
    compare_result("R2 writes while busy ignored", 3);
    snap = int'(spins);
    repeat (20) @(negedge clk);
    check("R9 done held", int'(done), 1);
    check("R9 spins held", int'(spins), snap);
  endtask

  task automatic t_restart();
    start_run(16'hBEEF, 1, 40);
    model_run(16'hBEEF, 1, 40);
    @(negedge clk);
    check("R9 done cleared on restart", int'(done), 0);
    wait_done("R9 restart");
    compare_result("R9 restart from current spins", 1);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_initial_energy();
    t_ferro();
    t_mixed_zero_seed();
    t_ignore_busy();
    t_restart();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule